// File: doc/BRIEF.md
# Multi-Core Debug TAP Selector

This block is the test access port of a four-core processor that exposes a single scan chain. A standard 16-state TAP controller, clocked by TCK, walks a 5-bit instruction register and a set of data registers. Two read-only words identify the device and describe its debug implementation. A third register is a 32-bit per-core debug control word, and it is routed to exactly one core at a time.

Four private instructions choose which core's debug logic sits behind the control register and the debug-boot instruction. The choice is held in a register of its own. It survives later instruction scans and returns to core 0 only on a TAP reset. Each core connects through a simple bus. The core presents its live control/status word, with its reset-occurred flag in bit 31. The block returns a one-cycle write strobe with masked write data, and a one-cycle boot request.

Top module: `mcore_dbg_tap`

## Requirements
- R1: TRST low, or five rising TCK edges with TMS high, puts the controller in Test-Logic-Reset. There the active instruction becomes 0x01 and the selected core becomes 0, so a data scan straight after reset returns 0x0000024F.
- R2: During Shift-IR the bits presented on TDO, least significant first, are the captured value 5'b00001.
- R3: With instruction 0x01 a 32-bit data scan shifts out 0x0000024F, least significant bit first.
- R4: With instruction 0x03 a 32-bit data scan shifts out 0x20404000, least significant bit first.
- R5: Instructions 0x14, 0x15, 0x16 and 0x17 select core 0, 1, 2 and 3. `core_sel` takes the new index on the rising edge that leaves Update-IR.
- R6: An Update-IR of any other instruction leaves `core_sel` and the core reached by instruction 0x0A unchanged.
- R7: With instruction 0x0A, Capture-DR loads the selected core's live `core_status` word, which then shifts out least significant bit first.
- R8: With instruction 0x0A, the rising edge leaving Update-DR raises, for one TCK cycle, only bit `core_sel` of `dbg_wr_en`. `dbg_wr_data` then equals the shifted-in word ANDed with 0x8000FFFF. A core clears its reset-occurred flag (bit 31) when written with a 0 there.
- R9: An Update-IR of instruction 0x0D raises, for one TCK cycle, only bit `core_sel` of `dbg_boot`, on the rising edge that leaves Update-IR.
- R10: Instruction 0x1F, any unassigned code, and the core-select and boot codes place a 1-bit bypass register between TDI and TDO. It captures 0, so an n-bit scan returns the input delayed by one bit.
- R11: TDO is 0 in every state other than Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, LSB of the active shift register |
| core_status | input | 128 | Live debug control word of each core, core c in bits [32c+31:32c] |
| dbg_wr_en | output | 4 | One-hot write strobe, one TCK cycle, to the selected core |
| dbg_wr_data | output | 32 | Masked control word written to the selected core |
| dbg_boot | output | 4 | One-hot debug-boot request, one TCK cycle |
| core_sel | output | 2 | Index of the core currently attached to the debug registers |

## Verification
TDO follows the shift register combinationally. The bench therefore samples it at the falling edge of every Shift-IR or Shift-DR cycle, so the first bit it reads is the captured bit 0. The core selection, the boot pulse and the write strobe all register on the rising edge that leaves an Update state. They are read at the falling edge that follows, and read again one cycle later to confirm each pulse lasts a single cycle. A control-register write reaches the modelled core on the next rising edge, so it is read back through a fresh Capture-DR scan, never straight after the strobe.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

  localparam int IR_W   = 5;
  localparam int DR_W   = 32;
  localparam int CSEL_W = 2;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_IMPL, DR_DBGCTL} dr_sel_e;

  localparam logic [IR_W-1:0] OP_IDCODE  = 5'h01;
  localparam logic [IR_W-1:0] OP_IMPL    = 5'h03;
  localparam logic [IR_W-1:0] OP_DBGCTL  = 5'h0A;
  localparam logic [IR_W-1:0] OP_DBGBOOT = 5'h0D;
  localparam logic [IR_W-1:0] OP_CSEL0   = 5'h14;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'h01;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
    dr_sel_e d;
    case (op)
      OP_IDCODE: d = DR_IDCODE;
      OP_IMPL:   d = DR_IMPL;
      OP_DBGCTL: d = DR_DBGCTL;
      default:   d = DR_BYPASS;
    endcase
    return d;
  endfunction

  function automatic logic csel_hit(input logic [IR_W-1:0] op);
    return op[IR_W-1:CSEL_W] == OP_CSEL0[IR_W-1:CSEL_W];
  endfunction

endpackage

// File: rtl/mdt_tap_fsm.sv
module mdt_tap_fsm
  import mdt_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_RESET;
    else         state_q <= tap_next(state_q, tms);
  end

  assign state = state_q;

  // run length of consecutive TMS-high edges, saturating at five
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             tms_run <= 3'd0;
    else if (!tms)           tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state_q == ST_RESET)); // R1

  AST_RESET_TO_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET && !tms) |=> (state_q == ST_IDLE)); // R1

endmodule

// File: rtl/mdt_ir_unit.sv
module mdt_ir_unit
  import mdt_pkg::*;
#(
  parameter int NCORES = 4
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  output logic [IR_W-1:0]   ir_op,
  output logic              ir_lsb,
  output logic [CSEL_W-1:0] core_sel,
  output logic [NCORES-1:0] dbg_boot
);

  logic [IR_W-1:0] ir_sr;
  logic            cap_ir, shf_ir, upd_ir, in_reset;
  logic            csel_take, boot_req, boot_q;

  assign cap_ir   = (state == ST_CAP_IR);
  assign shf_ir   = (state == ST_SHF_IR);
  assign upd_ir   = (state == ST_UPD_IR);
  assign in_reset = (state == ST_RESET);

  assign csel_take = upd_ir && csel_hit(ir_sr) && (int'(ir_sr[CSEL_W-1:0]) < NCORES);
  assign boot_req  = upd_ir && (ir_sr == OP_DBGBOOT);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sr <= IR_CAPTURE;
    else if (cap_ir) ir_sr <= IR_CAPTURE;
    else if (shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_op    <= OP_IDCODE;
      core_sel <= '0;
    end else if (in_reset) begin
      ir_op    <= OP_IDCODE;
      core_sel <= '0;
    end else if (upd_ir) begin
      ir_op <= ir_sr;
      if (csel_take) core_sel <= ir_sr[CSEL_W-1:0];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) boot_q <= 1'b0;
    else         boot_q <= boot_req;
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_boot
    assign dbg_boot[c] = boot_q && (core_sel == CSEL_W'(c));
  end

  assign ir_lsb = ir_sr[0];

  AST_RESET_DEFAULTS: assert property (@(posedge tck) disable iff (!trst_n)
    in_reset |=> (core_sel == '0 && ir_op == OP_IDCODE)); // R1

  AST_SEL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ir && !in_reset) |=> $stable(core_sel)); // R6

  AST_BOOT_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(dbg_boot)); // R9

  AST_BOOT_AFTER_UPD: assert property (@(posedge tck) disable iff (!trst_n)
    (|dbg_boot) |-> ($past(state) == ST_UPD_IR)); // R9

endmodule

// File: rtl/mdt_dr_unit.sv
module mdt_dr_unit
  import mdt_pkg::*;
#(
  parameter int              NCORES     = 4,
  parameter logic [DR_W-1:0] IDCODE_VAL = 32'h0000_024F,
  parameter logic [DR_W-1:0] IMPL_VAL   = 32'h2040_4000,
  parameter logic [DR_W-1:0] WR_MASK    = 32'h8000_FFFF
)(
  input  logic                   tck,
  input  logic                   trst_n,
  input  logic                   tdi,
  input  tap_state_e             state,
  input  logic [IR_W-1:0]        ir_op,
  input  logic [CSEL_W-1:0]      core_sel,
  input  logic [NCORES*DR_W-1:0] core_status,
  output logic                   dr_lsb,
  output logic [NCORES-1:0]      dbg_wr_en,
  output logic [DR_W-1:0]        dbg_wr_data
);

  dr_sel_e           dsel;
  logic              cap_dr, shf_dr, upd_dr, ctl_write;
  logic [DR_W-1:0]   dr_sr, sel_status;
  logic [DR_W-1:0]   stat_arr [NCORES];
  logic [NCORES-1:0] sel_onehot;

  assign dsel      = dr_decode(ir_op);
  assign cap_dr    = (state == ST_CAP_DR);
  assign shf_dr    = (state == ST_SHF_DR);
  assign upd_dr    = (state == ST_UPD_DR);
  assign ctl_write = upd_dr && (dsel == DR_DBGCTL);

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assign stat_arr[c]   = core_status[c*DR_W +: DR_W];
    assign sel_onehot[c] = (core_sel == CSEL_W'(c));
  end

  always_comb begin
    sel_status = '0;
    for (int c = 0; c < NCORES; c++) begin
      if (sel_onehot[c]) sel_status = stat_arr[c];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr_sr <= '0;
    end else if (cap_dr) begin
      case (dsel)
        DR_IDCODE: dr_sr <= IDCODE_VAL;
        DR_IMPL:   dr_sr <= IMPL_VAL;
        DR_DBGCTL: dr_sr <= sel_status;
        default:   dr_sr <= '0;
      endcase
    end else if (shf_dr) begin
      if (dsel == DR_BYPASS) dr_sr[0] <= tdi;
      else                   dr_sr    <= {tdi, dr_sr[DR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dbg_wr_en   <= '0;
      dbg_wr_data <= '0;
    end else begin
      dbg_wr_en <= ctl_write ? sel_onehot : '0;
      if (ctl_write) dbg_wr_data <= dr_sr & WR_MASK;
    end
  end

  assign dr_lsb = dr_sr[0];

  AST_WR_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(dbg_wr_en)); // R8

  AST_WR_AFTER_UPD: assert property (@(posedge tck) disable iff (!trst_n)
    (|dbg_wr_en) |-> ($past(state) == ST_UPD_DR && $past(ir_op) == OP_DBGCTL)); // R8

  AST_WR_SINGLE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
    (|dbg_wr_en) |=> (dbg_wr_en == '0)); // R8

  AST_WR_TARGET: assert property (@(posedge tck) disable iff (!trst_n)
    (|dbg_wr_en) |-> (dbg_wr_en == sel_onehot)); // R8

  AST_BYPASS_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(state) == ST_CAP_DR && $past(dsel) == DR_BYPASS) |-> (dr_lsb == 1'b0)); // R10

endmodule

// File: rtl/mcore_dbg_tap.sv
module mcore_dbg_tap
  import mdt_pkg::*;
#(
  parameter int              NCORES     = 4,
  parameter logic [DR_W-1:0] IDCODE_VAL = 32'h0000_024F,
  parameter logic [DR_W-1:0] IMPL_VAL   = 32'h2040_4000,
  parameter logic [DR_W-1:0] WR_MASK    = 32'h8000_FFFF
)(
  input  logic                   tck,
  input  logic                   trst_n,
  input  logic                   tms,
  input  logic                   tdi,
  output logic                   tdo,
  input  logic [NCORES*DR_W-1:0] core_status,
  output logic [NCORES-1:0]      dbg_wr_en,
  output logic [DR_W-1:0]        dbg_wr_data,
  output logic [NCORES-1:0]      dbg_boot,
  output logic [CSEL_W-1:0]      core_sel
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_op;
  logic            ir_lsb, dr_lsb;

  mdt_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  mdt_ir_unit #(.NCORES(NCORES)) u_ir (
    .tck      (tck),
    .trst_n   (trst_n),
    .tdi      (tdi),
    .state    (state),
    .ir_op    (ir_op),
    .ir_lsb   (ir_lsb),
    .core_sel (core_sel),
    .dbg_boot (dbg_boot)
  );

  mdt_dr_unit #(
    .NCORES     (NCORES),
    .IDCODE_VAL (IDCODE_VAL),
    .IMPL_VAL   (IMPL_VAL),
    .WR_MASK    (WR_MASK)
  ) u_dr (
    .tck         (tck),
    .trst_n      (trst_n),
    .tdi         (tdi),
    .state       (state),
    .ir_op       (ir_op),
    .core_sel    (core_sel),
    .core_status (core_status),
    .dr_lsb      (dr_lsb),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_data (dbg_wr_data)
  );

  always_comb begin
    case (state)
      ST_SHF_IR: tdo = ir_lsb;
      ST_SHF_DR: tdo = dr_lsb;
      default:   tdo = 1'b0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> (dbg_wr_en == '0 && dbg_boot == '0)); // R8

endmodule

// File: tb/mcore_dbg_tap_test.sv
module mcore_dbg_tap_test;

  localparam int          TCK_PERIOD = 10;
  localparam int          NC         = 4;
  localparam logic [31:0] ID_WORD    = 32'h0000_024F;
  localparam logic [31:0] IMPL_WORD  = 32'h2040_4000;
  localparam logic [31:0] WMASK      = 32'h8000_FFFF;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo;
  logic [NC*32-1:0] core_status;
  logic [NC-1:0]    dbg_wr_en, dbg_boot;
  logic [31:0]      dbg_wr_data;
  logic [1:0]       core_sel;

  always #(TCK_PERIOD/2) tck = ~tck;

  mcore_dbg_tap uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .core_status(core_status), .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
    .dbg_boot(dbg_boot), .core_sel(core_sel)
  );

  // core model: status word, reset-occurred flag in bit 31 (write 0 there to clear)
  function automatic logic [31:0] base_val(input int i);
    return 32'h8068_0000 | (32'(i) << 4);
  endfunction

  function automatic logic [31:0] apply_wr(input logic [31:0] old, input logic [31:0] wr);
    return (old & ~WMASK) | (wr & WMASK & 32'h7FFF_FFFF) | (old & wr & 32'h8000_0000);
  endfunction

  logic [31:0]   core_reg [NC];
  logic [NC-1:0] crst = '1;

  always @(posedge tck) begin
    for (int i = 0; i < NC; i++) begin
      if (crst[i])           core_reg[i] <= base_val(i);
      else if (dbg_wr_en[i]) core_reg[i] <= apply_wr(core_reg[i], dbg_wr_data);
    end
  end

  always_comb begin
    for (int i = 0; i < NC; i++) core_status[i*32 +: 32] = core_reg[i];
  end

  // bench-side expectations
  logic [31:0] exp_core [NC];
  int          exp_sel;
  logic [4:0]  cur_op;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] act_q [$];
  event        ev_res;
  logic [31:0] mon_a, mon_e;
  string       mon_t;

  initial begin
    forever begin
      @(ev_res);
      while (act_q.size() > 0) begin
        mon_a = act_q.pop_front();
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, mon_a, mon_e);
      end
    end
  end

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    o   = tdo;
    tms = m;
    tdi = d;
  endtask

  task automatic ir_scan(input logic [4:0] code);
    logic b;
    logic [4:0] got;
    got = '0;
    exp_q.push_back(32'h1);
    tag_q.push_back("R2 capture-IR pattern");
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int k = 0; k < 5; k++) begin
      step(k == 4, code[k], b);
      got[k] = b;
    end
    step(1, 0, b); step(0, 0, b);
    act_q.push_back({27'd0, got});
    -> ev_res;
    cur_op = code;
    if (code[4:2] == 3'b101) exp_sel = int'(code[1:0]);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input logic [31:0] exp, input string tag);
    logic b;
    logic [31:0] got;
    got = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], b);
      got[k] = b;
    end
    step(1, 0, b); step(0, 0, b);
    act_q.push_back(got);
    -> ev_res;
    if (cur_op == 5'h0A) exp_core[exp_sel] = apply_wr(exp_core[exp_sel], din);
  endtask

  logic [NC-1:0] pk_wr, pk_boot;
  logic [31:0]   pk_data;
  logic [1:0]    pk_sel;
  logic          pk_tdo;

  task automatic peek();
    @(negedge tck);
    pk_wr = dbg_wr_en; pk_boot = dbg_boot; pk_data = dbg_wr_data;
    pk_sel = core_sel; pk_tdo = tdo;
    tms = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic b;
    for (int i = 0; i < NC; i++) exp_core[i] = base_val(i);
    exp_sel = 0;
    cur_op  = 5'h01;
    repeat (4) @(negedge tck);
    crst   = '0;
    trst_n = 1'b1;

    // R1 reset state, R11 quiet TDO
    peek();
    check("R1 core_sel after TRST", 32'(pk_sel), 32'd0);
    check("R11 tdo outside shift", 32'(pk_tdo), 32'd0);
    check("R8 no write strobe at reset", 32'(pk_wr), 32'd0);
    check("R9 no boot at reset", 32'(pk_boot), 32'd0);
    dr_scan(32, 32'h0, ID_WORD, "R1 identification after TRST");

    // R4 and R3
    ir_scan(5'h03);
    dr_scan(32, 32'h0, IMPL_WORD, "R4 implementation word");
    ir_scan(5'h01);
    dr_scan(32, 32'hFFFF_FFFF, ID_WORD, "R3 identification word");

    // R7/R8 control register on core 0
    ir_scan(5'h0A);
    dr_scan(32, 32'h0, exp_core[0], "R7 core0 status capture");
    peek();
    check("R8 strobe to core0", 32'(pk_wr), 32'h1);
    check("R8 write data core0", pk_data, 32'h0);
    peek();
    check("R8 strobe lasts one cycle", 32'(pk_wr), 32'h0);
    check("R11 tdo in idle", 32'(pk_tdo), 32'd0);
    dr_scan(32, 32'h0, exp_core[0], "R8 reset flag cleared on core0");

    // R5 select core 1, R10 bypass under the select op
    ir_scan(5'h15);
    peek();
    check("R5 core_sel after 0x15", 32'(pk_sel), 32'd1);
    dr_scan(8, 32'hA5, 32'h4A, "R10 bypass under core-select op");
    ir_scan(5'h0A);
    dr_scan(32, 32'h8000_1234, exp_core[1], "R7 core1 status capture");
    peek();
    check("R8 strobe to core1", 32'(pk_wr), 32'h2);
    check("R8 write data core1", pk_data, 32'h8000_1234 & WMASK);
    dr_scan(32, 32'hFFFF_FFFF, exp_core[1], "R8 core1 after write");
    peek();
    check("R8 read-only bits masked", pk_data, 32'h8000_FFFF);

    // R6 selection survives other instructions
    ir_scan(5'h01);
    peek();
    check("R6 core_sel held after 0x01", 32'(pk_sel), 32'd1);
    ir_scan(5'h0A);
    dr_scan(32, 32'h0000_5555, exp_core[1], "R6 control still reaches core1");

    // R9 boot pulses
    ir_scan(5'h0D);
    peek();
    check("R9 boot to core1", 32'(pk_boot), 32'h2);
    peek();
    check("R9 boot lasts one cycle", 32'(pk_boot), 32'h0);
    ir_scan(5'h17);
    peek();
    check("R5 core_sel after 0x17", 32'(pk_sel), 32'd3);
    ir_scan(5'h0D);
    peek();
    check("R9 boot to core3", 32'(pk_boot), 32'h8);
    check("R6 boot op keeps selection", 32'(pk_sel), 32'd3);

    // R10 bypass codes
    ir_scan(5'h1F);
    dr_scan(8, 32'h3C, 32'h78, "R10 bypass code 0x1F");
    ir_scan(5'h07);
    dr_scan(4, 32'hB, 32'h6, "R10 unassigned code 0x07");

    // R7 reset flag set by a core reset on core 3
    @(negedge tck); crst = 4'b1000;
    @(negedge tck); crst = '0;
    exp_core[3] = base_val(3);
    ir_scan(5'h0A);
    dr_scan(32, 32'h0, exp_core[3], "R7 core3 reset flag set");
    dr_scan(32, 32'h0, exp_core[3], "R8 core3 reset flag cleared");

    // R1 five TMS-high reset
    for (int k = 0; k < 5; k++) step(1, 0, b);
    step(0, 0, b);
    exp_sel = 0;
    cur_op  = 5'h01;
    peek();
    check("R1 core_sel after TMS reset", 32'(pk_sel), 32'd0);
    dr_scan(32, 32'h0, ID_WORD, "R1 identification after TMS reset");
    ir_scan(5'h0A);
    dr_scan(32, 32'h0, exp_core[0], "R1 control back on core0");

    repeat (3) @(negedge tck);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R3 scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule